// File: doc/BRIEF.md
# Lane-Partitioned Saturating Add/Subtract Unit

This unit adds or subtracts two 64-bit words that it can split into independent lanes: eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes, or a single 64-bit lane. The carry ripples byte by byte. At each lane boundary the carry is cut and replaced by the lane's own carry-in, so neighbouring lanes never influence each other. Subtraction inverts the second operand and injects a carry of one at the bottom of every lane.

Each lane works as signed or unsigned and detects its own overflow. With saturation on, an overflowing lane is clamped to the extreme value in the direction of the overflow. With saturation off, the lane wraps modulo its width. In both cases the overflow is reported on one flag per byte. Every byte of a lane carries that lane's flag. Results and flags are captured in an output register, which can be removed by a parameter.

Top module: `simd_sat_addsub`

## Requirements
- R1: `lane_mode` selects the lane width: 0 gives 8-bit lanes, 1 gives 16-bit, 2 gives 32-bit and 3 gives one 64-bit lane. Lane k occupies result bits starting at k times the lane width. With saturation off, each lane equals the operation on the matching operand bits modulo 2^width.
- R2: No carry or borrow crosses a lane boundary. A lane's result depends only on that lane's operand bits.
- R3: With `op_sub`=1, each lane computes a minus b as a plus the bitwise inverse of b plus one. With `op_sub`=0 it computes a plus b.
- R4: In signed add (`is_signed`=1), a lane overflows exactly when both operands have the same sign bit and the result sign differs from it. Operands of opposite sign never overflow.
- R5: In signed subtract, a lane overflows exactly when the operands' sign bits differ and the result sign differs from the sign of a.
- R6: In unsigned add a lane overflows on a carry out of its top bit. In unsigned subtract it overflows when a < b.
- R7: With `sat_en`=1 in signed mode, a lane that overflows with a non-negative a becomes the largest positive value (0x7F, 0x7FFF, ...). With a negative a it becomes the most negative value (0x80, 0x8000, ...).
- R8: With `sat_en`=1 in unsigned mode, an overflowing add lane becomes all ones and an overflowing subtract lane becomes zero.
- R9: With `sat_en`=0, overflowing lanes keep the wrapped result, and their overflow flags are still set.
- R10: `ovf_flag[i]` belongs to result byte i (bits 8i+7..8i). Every byte of a lane shows that lane's overflow.
- R11: With the default `OUT_REG`=1, `result` and `ovf_flag` show the inputs of the previous rising clock edge. While `rst` is high at an edge, both are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the outputs |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| lane_mode | input | 2 | Lane width select (0: 8, 1: 16, 2: 32, 3: 64 bits) |
| op_sub | input | 1 | 1 subtracts opb from opa, 0 adds |
| is_signed | input | 1 | 1 selects two's-complement lanes |
| sat_en | input | 1 | 1 clamps overflowing lanes, 0 wraps |
| result | output | 64 | Per-lane result |
| ovf_flag | output | 8 | Per-byte overflow flag |

## Verification
The datapath has no internal state, so the output register is the only delay. Every result and flag is due exactly one rising edge after its operands and controls are applied. The bench changes the inputs on a falling edge, lets a single rising edge pass, and compares both outputs on the following falling edge, before it applies new inputs. The reset clear is checked on a falling edge, after a rising edge with `rst` high.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = 8;
    localparam int DATA_W    = BYTE_W * NUM_BYTES;

    // Lane width encoding: lane spans (1 << mode) bytes
    typedef enum logic [1:0] {
        LANE_B8  = 2'd0,
        LANE_H16 = 2'd1,
        LANE_W32 = 2'd2,
        LANE_D64 = 2'd3
    } lane_mode_e;

    typedef struct packed {
        lane_mode_e mode;
        logic       sub;
        logic       sgn;
        logic       sat;
    } op_ctl_t;

    // One byte slice of the carry chain
    typedef struct packed {
        logic [BYTE_W-1:0] sum;
        logic              cout;
        logic              a_msb;
        logic              bx_msb;   // msb of second operand after inversion for subtract
    } slice_t;

    function automatic int unsigned lane_bytes(lane_mode_e m);
        return 32'd1 << m;
    endfunction

endpackage

// File: rtl/simd_lane_map.sv
module simd_lane_map
    import simd_pkg::*;
#(
    parameter int NB = simd_pkg::NUM_BYTES
) (
    input  lane_mode_e                 mode,
    output logic [NB-1:0]              first_byte,
    output logic [NB-1:0]              last_byte,
    output logic [NB-1:0][$clog2(NB)-1:0] owner
);
    localparam int IDX_W = $clog2(NB);

    always_comb begin
        int unsigned lb;
        lb = lane_bytes(mode);
        for (int i = 0; i < NB; i++) begin
            first_byte[i] = ((i & (lb - 1)) == 0);
            last_byte[i]  = (((i + 1) & (lb - 1)) == 0);
            owner[i]      = IDX_W'(i | (lb - 1));   // top byte of the lane holding byte i
        end
    end

endmodule

// File: rtl/simd_carry_chain.sv
module simd_carry_chain
    import simd_pkg::*;
#(
    parameter int NB = simd_pkg::NUM_BYTES,
    parameter int BW = simd_pkg::BYTE_W
) (
    input  logic [NB*BW-1:0]   a,
    input  logic [NB*BW-1:0]   b,
    input  logic               sub,
    input  logic [NB-1:0]      first_byte,
    output slice_t [NB-1:0]    slc
);
    logic [NB-1:0] cin;
    logic [NB-1:0] cout;

    for (genvar g = 0; g < NB; g++) begin : g_byte
        logic [BW-1:0] a_b;
        logic [BW-1:0] bx_b;
        logic [BW:0]   s_w;

        assign a_b  = a[g*BW +: BW];
        assign bx_b = b[g*BW +: BW] ^ {BW{sub}};

        if (g == 0) begin : g_base
            assign cin[g] = sub;
        end else begin : g_link
            // carry is cut where a new lane begins
            assign cin[g] = first_byte[g] ? sub : cout[g-1];
        end

        assign s_w     = {1'b0, a_b} + {1'b0, bx_b} + {{BW{1'b0}}, cin[g]};
        assign cout[g] = s_w[BW];

        assign slc[g].sum    = s_w[BW-1:0];
        assign slc[g].cout   = s_w[BW];
        assign slc[g].a_msb  = a_b[BW-1];
        assign slc[g].bx_msb = bx_b[BW-1];
    end

endmodule

// File: rtl/simd_lane_fixup.sv
module simd_lane_fixup
    import simd_pkg::*;
#(
    parameter int NB = simd_pkg::NUM_BYTES,
    parameter int BW = simd_pkg::BYTE_W
) (
    input  slice_t [NB-1:0]               slc,
    input  op_ctl_t                       ctl,
    input  logic [NB-1:0]                 last_byte,
    input  logic [NB-1:0][$clog2(NB)-1:0] owner,
    output logic [NB*BW-1:0]              res,
    output logic [NB-1:0]                 ovf
);
    logic [NB-1:0] top_ovf;

    // Overflow as seen at each byte, meaningful only on a lane's top byte
    always_comb begin
        for (int i = 0; i < NB; i++) begin
            if (ctl.sgn)
                top_ovf[i] = (slc[i].a_msb == slc[i].bx_msb) &&
                             (slc[i].sum[BW-1] != slc[i].a_msb);
            else
                top_ovf[i] = ctl.sub ? ~slc[i].cout : slc[i].cout;
        end
    end

    // Broadcast the lane verdict and substitute the clamp value
    always_comb begin
        for (int i = 0; i < NB; i++) begin
            logic          neg;
            logic [BW-1:0] fill;
            neg    = slc[owner[i]].a_msb;
            ovf[i] = top_ovf[owner[i]];
            if (ctl.sgn)
                fill = last_byte[i] ? {neg, {(BW-1){~neg}}} : {BW{~neg}};
            else
                fill = {BW{~ctl.sub}};
            res[i*BW +: BW] = (ctl.sat && ovf[i]) ? fill : slc[i].sum;
        end
    end

endmodule

// File: rtl/simd_sat_addsub.sv
module simd_sat_addsub
    import simd_pkg::*;
#(
    parameter int NB      = simd_pkg::NUM_BYTES,
    parameter int BW      = simd_pkg::BYTE_W,
    parameter bit OUT_REG = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NB*BW-1:0]   opa,
    input  logic [NB*BW-1:0]   opb,
    input  logic [1:0]         lane_mode,
    input  logic               op_sub,
    input  logic               is_signed,
    input  logic               sat_en,
    output logic [NB*BW-1:0]   result,
    output logic [NB-1:0]      ovf_flag
);
    localparam int DW    = NB * BW;
    localparam int IDX_W = $clog2(NB);

    op_ctl_t                  ctl;
    logic [NB-1:0]            first_byte;
    logic [NB-1:0]            last_byte;
    logic [NB-1:0][IDX_W-1:0] owner;
    slice_t [NB-1:0]          slc;
    logic [DW-1:0]            res_c;
    logic [NB-1:0]            ovf_c;

    assign ctl.mode = lane_mode_e'(lane_mode);
    assign ctl.sub  = op_sub;
    assign ctl.sgn  = is_signed;
    assign ctl.sat  = sat_en;

    simd_lane_map #(.NB(NB)) u_map (
        .mode       (ctl.mode),
        .first_byte (first_byte),
        .last_byte  (last_byte),
        .owner      (owner)
    );

    simd_carry_chain #(.NB(NB), .BW(BW)) u_chain (
        .a          (opa),
        .b          (opb),
        .sub        (ctl.sub),
        .first_byte (first_byte),
        .slc        (slc)
    );

    simd_lane_fixup #(.NB(NB), .BW(BW)) u_fix (
        .slc        (slc),
        .ctl        (ctl),
        .last_byte  (last_byte),
        .owner      (owner),
        .res        (res_c),
        .ovf        (ovf_c)
    );

    if (OUT_REG) begin : g_oreg
        always_ff @(posedge clk) begin
            if (rst) begin
                result   <= '0;
                ovf_flag <= '0;
            end else begin
                result   <= res_c;
                ovf_flag <= ovf_c;
            end
        end
    end else begin : g_comb
        assign result   = res_c;
        assign ovf_flag = ovf_c;
    end

    AST_WIDE_FLAG_PAIR: assert property (@(posedge clk) disable iff (rst)
        (lane_mode != 2'd0) |-> (ovf_c[1] == ovf_c[0]));  // R10
    AST_UNS_ADD_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (sat_en && !is_signed && !op_sub && ovf_c[0]) |-> (res_c[BW-1:0] == {BW{1'b1}}));  // R8
    AST_UNS_SUB_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (sat_en && !is_signed && op_sub && ovf_c[0]) |-> (res_c[BW-1:0] == '0));  // R8
    AST_OPP_SIGN_ADD: assert property (@(posedge clk) disable iff (rst)
        (is_signed && !op_sub && lane_mode == 2'd0 && opa[BW-1] != opb[BW-1]) |-> !ovf_c[0]);  // R4
    AST_SELF_SUB_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_sub && opa == opb) |-> (res_c == '0 && ovf_c == '0));  // R3

endmodule

// File: tb/sim_simd_sat_addsub.sv
`timescale 1ns/1ps
module sim_simd_sat_addsub;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] opa = '0, opb = '0;
    logic [1:0]  lane_mode = '0;
    logic        op_sub = 1'b0, is_signed = 1'b0, sat_en = 1'b0;
    logic [63:0] result;
    logic [7:0]  ovf_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    simd_sat_addsub u0 (
        .clk(clk), .rst(rst), .opa(opa), .opb(opb), .lane_mode(lane_mode),
        .op_sub(op_sub), .is_signed(is_signed), .sat_en(sat_en),
        .result(result), .ovf_flag(ovf_flag)
    );

    function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                  input logic [1:0] m, input logic sb,
                                  input logic sg, input logic st,
                                  output logic [63:0] r, output logic [7:0] f);
        int lb, w;
        lb = 1 << m;
        w  = 8 * lb;
        r  = '0;
        f  = '0;
        for (int ln = 0; ln < 8 / lb; ln++) begin
            logic [63:0] mask, av, bv, rr;
            logic [64:0] s;
            logic        as, bs, rs, ov;
            mask = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
            av = (a >> (ln * w)) & mask;
            bv = (b >> (ln * w)) & mask;
            s  = sb ? ({1'b0, av} - {1'b0, bv}) : ({1'b0, av} + {1'b0, bv});
            rr = s[63:0] & mask;
            as = av[w-1]; bs = bv[w-1]; rs = rr[w-1];
            if (sg) ov = sb ? (as != bs && rs != as) : (as == bs && rs != as);
            else    ov = sb ? (av < bv) : s[w];
            if (st && ov) begin
                if (sg) rr = as ? (64'd1 << (w - 1)) : (mask >> 1);
                else    rr = sb ? 64'd0 : mask;
            end
            r = r | (rr << (ln * w));
            for (int k = 0; k < lb; k++) f[ln * lb + k] = ov;
        end
    endfunction

    task automatic check(input string tag, input logic [63:0] er, input logic [7:0] ef);
        total++;
        if (result !== er) begin
            bad++;
            $display("FAIL %s result actual=%h expected=%h", tag, result, er);
        end
        total++;
        if (ovf_flag !== ef) begin
            bad++;
            $display("FAIL %s ovf_flag actual=%b expected=%b", tag, ovf_flag, ef);
        end
    endtask

    task automatic run(input string tag, input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] m, input logic sb, input logic sg, input logic st);
        logic [63:0] er;
        logic [7:0]  ef;
        @(negedge clk);
        opa = a; opb = b; lane_mode = m; op_sub = sb; is_signed = sg; sat_en = st;
        model(a, b, m, sb, sg, st, er, ef);
        @(negedge clk);   // one rising edge has passed
        check(tag, er, ef);
    endtask

    task automatic run_exp(input string tag, input logic [63:0] a, input logic [63:0] b,
                           input logic [1:0] m, input logic sb, input logic sg, input logic st,
                           input logic [63:0] er, input logic [7:0] ef);
        @(negedge clk);
        opa = a; opb = b; lane_mode = m; op_sub = sb; is_signed = sg; sat_en = st;
        @(negedge clk);
        check(tag, er, ef);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        opa = 64'hFFFF_FFFF_FFFF_FFFF; opb = 64'h1; sat_en = 1'b1;
        repeat (2) @(negedge clk);
        check("R11 reset", 64'h0, 8'h0);
        rst = 1'b0;

        // R2: byte 0 carries out, byte 1 must stay 0 in 8-bit mode; 16-bit mode absorbs it
        run_exp("R2 isolate8", 64'h00FF, 64'h0001, 2'd0, 1'b0, 1'b0, 1'b0, 64'h0000, 8'h01);
        run_exp("R1 join16", 64'h00FF, 64'h0001, 2'd1, 1'b0, 1'b0, 1'b0, 64'h0100, 8'h00);
        run_exp("R1 full64", 64'h0000_0000_FFFF_FFFF, 64'h1, 2'd3, 1'b0, 1'b0, 1'b0,
                64'h0000_0001_0000_0000, 8'h00);
        // R3: subtract in 32-bit lanes, borrow stays in lane 0
        run_exp("R3 sub32", 64'h0000_0005_0000_0000, 64'h0000_0000_0000_0001, 2'd2,
                1'b1, 1'b0, 1'b0, 64'h0000_0005_FFFF_FFFF, 8'h0F);
        // R4: 0x7F+0x01 overflows positive; opposite signs do not
        run_exp("R4 pos8", 64'h7F, 64'h01, 2'd0, 1'b0, 1'b1, 1'b0, 64'h80, 8'h01);
        run_exp("R4 opp8", 64'h7F, 64'hFF, 2'd0, 1'b0, 1'b1, 1'b0, 64'h7E, 8'h00);
        // R5: 0x80 - 0x01 overflows, clamps to 0x80 when saturating
        run_exp("R5 sub8", 64'h80, 64'h01, 2'd0, 1'b1, 1'b1, 1'b0, 64'h7F, 8'h01);
        run_exp("R7 negclamp", 64'h80, 64'h01, 2'd0, 1'b1, 1'b1, 1'b1, 64'h80, 8'h01);
        run_exp("R7 posclamp16", 64'h7FFF, 64'h0001, 2'd1, 1'b0, 1'b1, 1'b1, 64'h7FFF, 8'h03);
        // R6 / R8 / R9 unsigned
        run_exp("R6 uadd", 64'hFF, 64'h01, 2'd0, 1'b0, 1'b0, 1'b0, 64'h00, 8'h01);
        run_exp("R8 uaddsat", 64'hFF, 64'h01, 2'd0, 1'b0, 1'b0, 1'b1, 64'hFF, 8'h01);
        run_exp("R8 usubsat", 64'h00, 64'h01, 2'd0, 1'b1, 1'b0, 1'b1, 64'h00, 8'h01);
        run_exp("R9 wrap", 64'h00, 64'h01, 2'd0, 1'b1, 1'b0, 1'b0, 64'hFF, 8'h01);
        // R10: 32-bit upper lane overflow replicated on flags 7..4
        run_exp("R10 spread", 64'h7FFF_FFFF_0000_0000, 64'h0000_0001_0000_0000, 2'd2,
                1'b0, 1'b1, 1'b1, 64'h7FFF_FFFF_0000_0000, 8'hF0);
        run("R7 min64", 64'h8000_0000_0000_0000, 64'h1, 2'd3, 1'b1, 1'b1, 1'b1);

        for (int n = 0; n < 600; n++) begin
            logic [63:0] a, b;
            a = {$urandom(), $urandom()};
            b = {$urandom(), $urandom()};
            if (n % 5 == 0) b = a ^ 64'h8080_8080_8080_8080;
            run("R1 random", a, b, 2'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()));
        end

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R11 rereset", 64'h0, 8'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule